// File: doc/BRIEF.md
# Sync Polarity Detector and Output Router

This block watches a pair of separate horizontal and vertical sync inputs and tells the rest of the chip whether each one is toggling and which sense it has. The sense is found by taking the input level at a fixed interval and counting how many of a block of samples were high. A short high pulse in a mostly low waveform means positive sync. Whether a line is alive is judged by an edge timeout.

The same block drives the two sync output pins. For each pin it picks one of three sources. The direct input serves separate sync. Composite sync uses the raw H input and the separator's V output. A free-running generator overrides both. The picked signal is first brought to a positive sense and then driven with the sense the control bits ask for. An active-low enable per pin decides whether the pin carries sync or is left to general I/O.

The control bits come from a register bank outside this block. The separator and the free-run generator are also outside it.

Top module: `hv_sync_router`

## Requirements
- R1: At the end of each window of WIN_SAMPLES samples, a channel's polarity flag (`h_pol`, `v_pol`) becomes 1 (positive) if the input was high in fewer than WIN_SAMPLES/2 of the samples. Otherwise it becomes 0 (negative), and exactly half high also gives 0.
- R2: One sample is taken every SAMPLE_DIV clocks. A polarity flag changes only in the cycle that follows the last sample of a window, and it holds its value between window ends.
- R3: A presence flag (`h_present`, `v_present`) becomes 1 no later than 4 clocks after an edge on its input. It becomes 0 once TIMEOUT clocks pass with no edge.
- R4: A pin's enable (`h_oe`, `v_oe`) is 1 exactly when its active-low enable input is 0. While the enable is 0, the pin drive value is 0.
- R5: With `frun_n`=1 and `comp_sel`=0 (separate sync), each drive equals its raw input XOR its detected polarity XOR its requested output polarity. This path is combinational and has no register.
- R6: With `frun_n`=1 and `comp_sel`=1 (composite sync), H is driven as in R5 from `hs_in`. V is driven from `sep_vs`, taken as positive-going, as `sep_vs` XOR NOT `vpol_out`. In this mode `vs_in` has no effect on the V drive.
- R7: With `frun_n`=0, each drive equals its free-run input, taken as positive-going, XOR NOT its requested output polarity. This holds whatever the value of `comp_sel`.
- R8: After reset, both presence flags and both polarity flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_in | input | 1 | Raw horizontal sync input (or composite sync) |
| vs_in | input | 1 | Raw vertical sync input |
| sep_vs | input | 1 | Vertical sync from the composite separator, positive-going |
| fr_hs | input | 1 | Free-run horizontal sync, positive-going |
| fr_vs | input | 1 | Free-run vertical sync, positive-going |
| comp_sel | input | 1 | 1 selects composite input handling |
| frun_n | input | 1 | 0 routes free-run sync to the outputs |
| hen_n | input | 1 | 0 enables the H sync output pin |
| ven_n | input | 1 | 0 enables the V sync output pin |
| hpol_out | input | 1 | Requested H output sense, 1 positive |
| vpol_out | input | 1 | Requested V output sense, 1 positive |
| h_present | output | 1 | H input shows activity |
| v_present | output | 1 | V input shows activity |
| h_pol | output | 1 | Detected H polarity, 1 positive |
| v_pol | output | 1 | Detected V polarity, 1 positive |
| h_drv | output | 1 | H pin drive value |
| v_drv | output | 1 | V pin drive value |
| h_oe | output | 1 | H pin acts as sync output |
| v_oe | output | 1 | V pin acts as sync output |

## Verification
The assertions check on every cycle that a disabled pin drives 0 and that a polarity flag moves only after a window ends. They also check that a presence flag rises only after an edge and falls only after a timeout, and that the free-run and composite V drives follow their sources. Only the bench scenarios can show the R1 thresholds, including the exact-half case. They are also needed for the direct-path inversion that depends on a detected sense, for `vs_in` having no effect in composite mode, and for the real durations of presence loss and recovery.

// File: rtl/hv_sync_pkg.sv
`timescale 1ns/1ps
package hv_sync_pkg;
    localparam int CH_H = 0;
    localparam int CH_V = 1;
    localparam int N_CH = 2;

    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_COMP   = 2'd1,
        SRC_FREE   = 2'd2
    } route_src_e;

    typedef struct packed {
        route_src_e src;
        logic       pos_level;
        logic       value;
    } route_t;
endpackage

// File: rtl/sync_level_sampler.sv
`timescale 1ns/1ps
module sync_level_sampler #(
    parameter int SAMPLE_DIV  = 4,
    parameter int WIN_SAMPLES = 256,
    parameter int TIMEOUT     = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_raw,
    output logic polarity,
    output logic present,
    output logic win_done,
    output logic edge_seen,
    output logic tmo_hit
);
    localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam int SMP_W = (WIN_SAMPLES > 1) ? $clog2(WIN_SAMPLES) : 1;
    localparam int HI_W  = $clog2(WIN_SAMPLES + 1);
    localparam int TMO_W = $clog2(TIMEOUT + 1);
    localparam logic [DIV_W-1:0] DIV_MAX  = DIV_W'(SAMPLE_DIV - 1);
    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(WIN_SAMPLES - 1);
    localparam logic [HI_W-1:0]  HALF     = HI_W'(WIN_SAMPLES / 2);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

    typedef struct packed {
        logic             sync_a;
        logic             sync_b;
        logic             last;
        logic [DIV_W-1:0] div;
        logic [SMP_W-1:0] smp;
        logic [HI_W-1:0]  hi;
        logic [TMO_W-1:0] tmo;
        logic             present;
        logic             pol;
    } smp_state_t;

    smp_state_t st_d, st_q;
    logic       tick_c, done_c, edge_c, tmo_c;
    logic [HI_W-1:0] hi_sum_c;

    always_comb begin
        st_d     = st_q;
        st_d.sync_a = sync_raw;
        st_d.sync_b = st_q.sync_a;
        st_d.last   = st_q.sync_b;

        edge_c   = st_q.sync_b ^ st_q.last;
        tick_c   = (st_q.div == DIV_MAX);
        done_c   = tick_c && (st_q.smp == SMP_LAST);
        hi_sum_c = st_q.hi + HI_W'(st_q.sync_b);
        tmo_c    = !edge_c && (st_q.tmo == TMO_LAST);

        st_d.div = tick_c ? '0 : st_q.div + 1'b1;

        if (tick_c) begin
            if (done_c) begin
                st_d.pol = (hi_sum_c < HALF);
                st_d.hi  = '0;
                st_d.smp = '0;
            end else begin
                st_d.hi  = hi_sum_c;
                st_d.smp = st_q.smp + 1'b1;
            end
        end

        if (edge_c) begin
            st_d.tmo     = '0;
            st_d.present = 1'b1;
        end else if (tmo_c) begin
            st_d.present = 1'b0;
        end else begin
            st_d.tmo = st_q.tmo + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign polarity  = st_q.pol;
    assign present   = st_q.present;
    assign win_done  = done_c;
    assign edge_seen = edge_c;
    assign tmo_hit   = tmo_c;
endmodule

// File: rtl/sync_pin_route.sv
`timescale 1ns/1ps
module sync_pin_route
    import hv_sync_pkg::*;
#(
    parameter bit COMP_RAW = 1'b1
) (
    input  logic direct_in,
    input  logic comp_in,
    input  logic free_in,
    input  logic det_pol,
    input  logic out_pol,
    input  logic comp_sel,
    input  logic frun_n,
    input  logic en_n,
    output logic pin_drv,
    output logic pin_oe
);
    logic   comp_pos;
    route_t rt;

    // Composite source is either the raw line (needs its detected sense
    // removed) or an already positive-going separated pulse.
    generate
        if (COMP_RAW) begin : g_comp_raw
            assign comp_pos = comp_in ^ ~det_pol;
        end else begin : g_comp_sep
            assign comp_pos = comp_in;
        end
    endgenerate

    always_comb begin
        rt = '0;
        if (!frun_n) begin
            rt.src = SRC_FREE;
        end else if (comp_sel) begin
            rt.src = SRC_COMP;
        end else begin
            rt.src = SRC_DIRECT;
        end
        case (rt.src)
            SRC_DIRECT: rt.pos_level = direct_in ^ ~det_pol;
            SRC_COMP:   rt.pos_level = comp_pos;
            SRC_FREE:   rt.pos_level = free_in;
            default:    rt.pos_level = 1'b0;
        endcase
        rt.value = rt.pos_level ^ ~out_pol;
    end

    assign pin_oe  = ~en_n;
    assign pin_drv = pin_oe & rt.value;
endmodule

// File: rtl/hv_sync_router.sv
`timescale 1ns/1ps
module hv_sync_router
    import hv_sync_pkg::*;
#(
    parameter int SAMPLE_DIV  = 4,
    parameter int WIN_SAMPLES = 256,
    parameter int TIMEOUT     = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_in,
    input  logic vs_in,
    input  logic sep_vs,
    input  logic fr_hs,
    input  logic fr_vs,
    input  logic comp_sel,
    input  logic frun_n,
    input  logic hen_n,
    input  logic ven_n,
    input  logic hpol_out,
    input  logic vpol_out,
    output logic h_present,
    output logic v_present,
    output logic h_pol,
    output logic v_pol,
    output logic h_drv,
    output logic v_drv,
    output logic h_oe,
    output logic v_oe
);
    logic [N_CH-1:0] raw_w, comp_w, free_w, opol_w, en_w;
    logic [N_CH-1:0] pol_w, pres_w, done_w, edge_w, tmo_w, drv_w, oe_w;

    assign raw_w  = {vs_in,    hs_in};
    assign comp_w = {sep_vs,   hs_in};
    assign free_w = {fr_vs,    fr_hs};
    assign opol_w = {vpol_out, hpol_out};
    assign en_w   = {ven_n,    hen_n};

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            sync_level_sampler #(
                .SAMPLE_DIV (SAMPLE_DIV),
                .WIN_SAMPLES(WIN_SAMPLES),
                .TIMEOUT    (TIMEOUT)
            ) smp_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_raw (raw_w[ch]),
                .polarity (pol_w[ch]),
                .present  (pres_w[ch]),
                .win_done (done_w[ch]),
                .edge_seen(edge_w[ch]),
                .tmo_hit  (tmo_w[ch])
            );

            sync_pin_route #(
                .COMP_RAW(ch == CH_H)
            ) route_i (
                .direct_in(raw_w[ch]),
                .comp_in  (comp_w[ch]),
                .free_in  (free_w[ch]),
                .det_pol  (pol_w[ch]),
                .out_pol  (opol_w[ch]),
                .comp_sel (comp_sel),
                .frun_n   (frun_n),
                .en_n     (en_w[ch]),
                .pin_drv  (drv_w[ch]),
                .pin_oe   (oe_w[ch])
            );
        end
    endgenerate

    assign h_present = pres_w[CH_H];
    assign v_present = pres_w[CH_V];
    assign h_pol     = pol_w[CH_H];
    assign v_pol     = pol_w[CH_V];
    assign h_drv     = drv_w[CH_H];
    assign v_drv     = drv_w[CH_V];
    assign h_oe      = oe_w[CH_H];
    assign v_oe      = oe_w[CH_V];
endmodule

// File: rtl/hv_sync_router_chk.sv
`timescale 1ns/1ps
module hv_sync_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sep_vs,
    input logic       fr_hs,
    input logic       fr_vs,
    input logic       comp_sel,
    input logic       frun_n,
    input logic       hpol_out,
    input logic       vpol_out,
    input logic       h_present,
    input logic       v_present,
    input logic       h_pol,
    input logic       v_pol,
    input logic       h_drv,
    input logic       v_drv,
    input logic       h_oe,
    input logic       v_oe,
    input logic [1:0] done_w,
    input logic [1:0] edge_w,
    input logic [1:0] tmo_w
);
    assert_idle_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_oe |-> !h_drv) and (!v_oe |-> !v_drv));

    assert_pol_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(h_pol) |-> $past(done_w[0])) and (!$stable(v_pol) |-> $past(done_w[1])));

    assert_present_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(h_present) |-> $past(edge_w[0])) and ($rose(v_present) |-> $past(edge_w[1])));

    assert_present_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(h_present) |-> $past(tmo_w[0])) and ($fell(v_present) |-> $past(tmo_w[1])));

    assert_free_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frun_n && h_oe && v_oe) |-> (h_drv == (fr_hs ^ !hpol_out)) && (v_drv == (fr_vs ^ !vpol_out)));

    assert_comp_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frun_n && comp_sel && v_oe) |-> (v_drv == (sep_vs ^ !vpol_out)));
endmodule

bind hv_sync_router hv_sync_router_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sep_vs   (sep_vs),
    .fr_hs    (fr_hs),
    .fr_vs    (fr_vs),
    .comp_sel (comp_sel),
    .frun_n   (frun_n),
    .hpol_out (hpol_out),
    .vpol_out (vpol_out),
    .h_present(h_present),
    .v_present(v_present),
    .h_pol    (h_pol),
    .v_pol    (v_pol),
    .h_drv    (h_drv),
    .v_drv    (v_drv),
    .h_oe     (h_oe),
    .v_oe     (v_oe),
    .done_w   (done_w),
    .edge_w   (edge_w),
    .tmo_w    (tmo_w)
);

// File: tb/hv_sync_router_tb_top.sv
`timescale 1ns/1ps
module hv_sync_router_tb_top;
    localparam int SDIV = 64;
    localparam int WIN  = 16;
    localparam int TMO  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_in = 1'b0, vs_in = 1'b0, sep_vs = 1'b0, fr_hs = 1'b0, fr_vs = 1'b0;
    logic comp_sel = 1'b0, frun_n = 1'b1, hen_n = 1'b1, ven_n = 1'b1;
    logic hpol_out = 1'b0, vpol_out = 1'b0;
    logic h_present, v_present, h_pol, v_pol, h_drv, v_drv, h_oe, v_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hv_sync_router #(
        .SAMPLE_DIV (SDIV),
        .WIN_SAMPLES(WIN),
        .TIMEOUT    (TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .sep_vs(sep_vs),
        .fr_hs(fr_hs), .fr_vs(fr_vs), .comp_sel(comp_sel), .frun_n(frun_n),
        .hen_n(hen_n), .ven_n(ven_n), .hpol_out(hpol_out), .vpol_out(vpol_out),
        .h_present(h_present), .v_present(v_present), .h_pol(h_pol), .v_pol(v_pol),
        .h_drv(h_drv), .v_drv(v_drv), .h_oe(h_oe), .v_oe(v_oe)
    );

    // Bits: 12 frun_n, 11 comp_sel, 10 hen_n, 9 ven_n, 8 hpol_out, 7 vpol_out,
    // 6 hs_in, 5 vs_in, 4 sep_vs, 3 fr_hs, 2 fr_vs, 1 exp h_drv, 0 exp v_drv.
    // Detected polarity of both channels is 0 throughout this table.
    localparam logic [12:0] VEC [12] = '{
        13'b1_0_0_0_0_0_1_0_0_0_0_1_0,
        13'b1_0_0_0_1_1_1_1_0_0_0_0_0,
        13'b1_0_0_0_1_0_0_1_0_0_0_1_1,
        13'b1_1_0_0_0_1_1_0_1_0_0_1_1,
        13'b1_1_0_0_0_0_0_1_1_0_0_0_0,
        13'b1_1_0_0_1_1_1_1_0_0_0_0_0,
        13'b0_0_0_0_1_1_0_1_0_1_0_1_0,
        13'b0_1_0_0_0_0_1_0_1_1_1_0_0,
        13'b0_0_0_0_0_1_0_0_0_0_1_1_1,
        13'b1_0_1_1_0_0_1_1_0_0_0_0_0,
        13'b1_0_1_0_0_0_1_1_0_0_0_0_1,
        13'b0_0_0_1_0_0_0_0_0_0_1_1_0
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic pulse_train(input bit on_v, input int hi, input int per, input int reps);
        for (int r = 0; r < reps; r++) begin
            for (int c = 0; c < per; c++) begin
                @(negedge clk);
                if (on_v) vs_in = (c < hi);
                else      hs_in = (c < hi);
            end
        end
    endtask

    task automatic hold_level(input bit on_v, input logic lvl, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (on_v) vs_in = lvl;
            else      hs_in = lvl;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R8 reset state
        check("R8 h_present after reset", h_present, 1'b0);
        check("R8 v_present after reset", v_present, 1'b0);
        check("R8 h_pol after reset", h_pol, 1'b0);
        check("R8 v_pol after reset", v_pol, 1'b0);
        check("R4 h_oe with hen_n=1", h_oe, 1'b0);
        check("R4 h_drv idle", h_drv, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Routing table, combinational path
        for (int i = 0; i < 12; i++) begin
            string tag;
            @(negedge clk);
            {frun_n, comp_sel, hen_n, ven_n, hpol_out, vpol_out,
             hs_in, vs_in, sep_vs, fr_hs, fr_vs} = VEC[i][12:2];
            #1;
            if (!frun_n)      tag = "R7";
            else if (hen_n || ven_n) tag = "R4";
            else if (comp_sel) tag = "R6";
            else               tag = "R5";
            check($sformatf("%s row %0d h_drv", tag, i), h_drv, VEC[i][1]);
            check($sformatf("%s row %0d v_drv", tag, i), v_drv, VEC[i][0]);
            check($sformatf("R4 row %0d h_oe", i), h_oe, !hen_n);
            check($sformatf("R4 row %0d v_oe", i), v_oe, !ven_n);
        end

        @(negedge clk);
        {frun_n, comp_sel, hen_n, ven_n, hpol_out, vpol_out} = 6'b1_0_0_0_1_1;
        hs_in = 1'b0; vs_in = 1'b0; sep_vs = 1'b0; fr_hs = 1'b0; fr_vs = 1'b0;

        // R1 short high pulses on H: 2 of 16 samples high -> positive
        pulse_train(1'b0, 64, 512, 6);
        #1;
        check("R1 h_pol short high pulses", h_pol, 1'b1);
        check("R3 h_present while toggling", h_present, 1'b1);
        // R5 with detected positive and requested positive: no inversion
        check("R5 h_drv follows low input", h_drv, 1'b0);
        @(negedge clk); hs_in = 1'b1; #1;
        check("R5 h_drv follows high input", h_drv, 1'b1);

        // R1 exact half: 8 of 16 high -> negative
        pulse_train(1'b0, 64, 128, 24);
        #1;
        check("R1 h_pol exact half", h_pol, 1'b0);

        // R1 on V: short pulses positive, then long pulses negative
        pulse_train(1'b1, 64, 512, 6);
        #1;
        check("R1 v_pol short high pulses", v_pol, 1'b1);
        check("R3 v_present while toggling", v_present, 1'b1);
        // R2: a brief constant high cannot tip the window already running
        hold_level(1'b1, 1'b1, 100);
        #1;
        check("R2 v_pol held between windows", v_pol, 1'b1);
        hold_level(1'b1, 1'b1, 2200);
        #1;
        check("R2 v_pol updated after full window", v_pol, 1'b0);
        pulse_train(1'b1, 448, 512, 6);
        #1;
        check("R1 v_pol long high pulses", v_pol, 1'b0);

        // R6: vs_in has no effect on V drive in composite mode
        @(negedge clk);
        comp_sel = 1'b1; vpol_out = 1'b1; sep_vs = 1'b1; vs_in = 1'b0; #1;
        check("R6 v_drv from separator", v_drv, 1'b1);
        @(negedge clk); vs_in = 1'b1; #1;
        check("R6 vs_in ignored", v_drv, 1'b1);
        comp_sel = 1'b0;

        // R3 loss of activity and recovery on H
        hold_level(1'b0, 1'b0, TMO + 40);
        #1;
        check("R3 h_present cleared after timeout", h_present, 1'b0);
        @(negedge clk); hs_in = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check("R3 h_present back within 4 clocks", h_present, 1'b1);

        finish_run();
    end
endmodule